// File: doc/BRIEF.md
# Indirect Memory Access Controller

This block lets a host processor reach a large internal switch memory through four small registers instead of a wide memory-mapped window. The host places the word to store in a data-write register, selects the memory in a control register, and writes an address-buffer register that carries a stream number, a channel number and two start bits. A 0-to-1 change of a start bit launches the transfer. The transfer is carried out only in a free access slot of the memory. That slot comes round once every `SLOT_PERIOD` clocks.

When the transfer finishes, a done flag rises in the address-buffer register and the start bit that launched it drops. A read leaves its result in the data-read register. The connection memory can be read and written. The data memory can only be read; in this block it is a fixed computed pattern standing for the switched samples.

Top module: `ind_mem_ctrl`

## Requirements
- R1: After reset every host register reads as zero: control (address 0), data-write (1), address buffer (2) and data-read (3).
- R2: Start bits are accepted only while control bit 0 (mode enable) is 1. While it is 0, start bits read back as 0 and nothing is launched. Clearing it during a transfer cancels the transfer: no done flag, start bits at 0, data-read register unchanged.
- R3: A write starts when address-buffer bit 13 goes from 0 to 1. It copies the data-write register into the connection-memory word at stream bits [4:0] and channel bits [11:5], provided control bits [3:1] select the connection memory (any value except 1).
- R4: A read starts when address-buffer bit 12 goes from 0 to 1. It loads the addressed memory word into the data-read register.
- R5: Done flag bit 14 of the address buffer rises 2 to 5 clock edges after the edge that accepted the start (default `SLOT_PERIOD` of 4). On that same edge the start bit that launched the transfer returns to 0.
- R6: The done flag stays at 1 until the next start is accepted. It reads 0 right after that edge.
- R7: If both start bits rise in one host write, only the write is performed. The read start bit stays 0 and the data-read register keeps its value.
- R8: While a transfer is pending, host writes to the address buffer (fields and start bits), the data-write register and the memory-select field are ignored. This includes a write that lands on the completing edge.
- R9: With control bits [3:1] = 1 the data memory is addressed. Writes to it are discarded and leave the connection memory untouched. A read of stream s, channel c returns the upper bits all ones, bits [11:5] = c and bits [4:0] = s (0xF000 + 32c + s at 16 bits).
- R10: A stream at or above `NUM_STREAMS`, or a channel at or above `NUM_CHANS`, is out of range. Reads of it return all zeros and writes to it change no memory word.
- R11: Register reads have zero wait states: `rdata_o` shows the register selected by `addr_i` in the same cycle. Host writes to the data-read register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 control, 1 data-write, 2 address buffer, 3 data-read |
| we_i | input | 1 | Register write strobe, sampled at the rising clock edge |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Selected register contents, combinational |

## Verification
The host can write the address buffer on the very edge where a pending transfer completes. Completion and a new start therefore meet in one cycle. The bench provokes this by holding a write strobe with a fresh read start and new stream and channel fields on every cycle of a pending write. It drops the strobe only at the first sample that shows the done flag, so one of its writes always coincides with the completion edge. It then requires the address buffer to show done set, both start bits clear and the original fields, and the memory to hold the value from the first write.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int STREAM_W = 5;
  localparam int CHAN_W   = 7;
  localparam int SEL_W    = 3;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_WDATA = 2'd1,
    REG_ABUF  = 2'd2,
    REG_RDATA = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SEL_LSB  = 1;
  localparam int ABUF_CH_LSB   = STREAM_W;
  localparam int ABUF_RD_BIT   = STREAM_W + CHAN_W;
  localparam int ABUF_WR_BIT   = ABUF_RD_BIT + 1;
  localparam int ABUF_DONE_BIT = ABUF_WR_BIT + 1;

  localparam logic [SEL_W-1:0] SEL_DATA_MEM = 3'd1;

  typedef struct packed {
    logic                is_wr;
    logic                data_mem;
    logic [STREAM_W-1:0] stream;
    logic [CHAN_W-1:0]   chan;
  } xfer_t;
endpackage

// File: rtl/imc_host_regs.sv
module imc_host_regs
  import imc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              exec_i,
  input  logic              done_i,
  input  logic              rd_load_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              launch_o,
  output xfer_t             xfer_o,
  output logic [DATA_W-1:0] wdata_reg_o,
  output logic              mode_en_o,
  output logic              wr_start_o,
  output logic              rd_start_o
);
  logic                mode_en_q;
  logic [SEL_W-1:0]    sel_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdreg_q;
  logic [STREAM_W-1:0] stream_q;
  logic [CHAN_W-1:0]   chan_q;
  logic                wr_start_q, rd_start_q;

  logic wr_ctrl, wr_wdat, wr_abuf;
  logic wr_rise, rd_rise;

  assign wr_ctrl = we_i && (addr_i == REG_CTRL);
  assign wr_wdat = we_i && (addr_i == REG_WDATA) && !busy_i;
  assign wr_abuf = we_i && (addr_i == REG_ABUF);

  // edge detect against the stored bit; busy blocks every new start
  assign wr_rise = wr_abuf && mode_en_q && !busy_i &&
                   wdata_i[ABUF_WR_BIT] && !wr_start_q;
  assign rd_rise = wr_abuf && mode_en_q && !busy_i &&
                   wdata_i[ABUF_RD_BIT] && !rd_start_q && !wr_rise;
  assign launch_o = wr_rise || rd_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_en_q  <= 1'b0;
      sel_q      <= '0;
      wdata_q    <= '0;
      rdreg_q    <= '0;
      stream_q   <= '0;
      chan_q     <= '0;
      wr_start_q <= 1'b0;
      rd_start_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_en_q <= wdata_i[CTRL_EN_BIT];
        if (!busy_i) sel_q <= wdata_i[CTRL_SEL_LSB +: SEL_W];
      end
      if (wr_wdat) wdata_q <= wdata_i;
      if (wr_abuf && !busy_i) begin
        stream_q <= wdata_i[STREAM_W-1:0];
        chan_q   <= wdata_i[ABUF_CH_LSB +: CHAN_W];
      end
      if (!mode_en_q || exec_i) begin
        wr_start_q <= 1'b0;
        rd_start_q <= 1'b0;
      end else if (launch_o) begin
        wr_start_q <= wr_rise;
        rd_start_q <= rd_rise;
      end
      if (rd_load_i) rdreg_q <= rd_word_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_EN_BIT]              = mode_en_q;
        rdata_o[CTRL_SEL_LSB +: SEL_W]    = sel_q;
      end
      REG_WDATA: rdata_o = wdata_q;
      REG_ABUF: begin
        rdata_o[STREAM_W-1:0]             = stream_q;
        rdata_o[ABUF_CH_LSB +: CHAN_W]    = chan_q;
        rdata_o[ABUF_RD_BIT]              = rd_start_q;
        rdata_o[ABUF_WR_BIT]              = wr_start_q;
        rdata_o[ABUF_DONE_BIT]            = done_i;
      end
      default: rdata_o = rdreg_q;
    endcase
  end

  assign xfer_o.is_wr    = wr_start_q;
  assign xfer_o.data_mem = (sel_q == SEL_DATA_MEM);
  assign xfer_o.stream   = stream_q;
  assign xfer_o.chan     = chan_q;
  assign wdata_reg_o     = wdata_q;
  assign mode_en_o       = mode_en_q;
  assign wr_start_o      = wr_start_q;
  assign rd_start_o      = rd_start_q;
endmodule

// File: rtl/imc_access_seq.sv
module imc_access_seq #(
  parameter int SLOT_PERIOD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic mode_en_i,
  output logic busy_o,
  output logic exec_o,
  output logic done_o
);
  localparam int CNT_W = (SLOT_PERIOD > 1) ? $clog2(SLOT_PERIOD) : 1;
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_PERIOD - 1);

  logic [CNT_W-1:0] slot_q;
  logic             slot_free;
  logic             pending_q, armed_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 slot_q <= '0;
    else if (slot_q == SLOT_LAST) slot_q <= '0;
    else                         slot_q <= slot_q + 1'b1;
  end

  assign slot_free = (slot_q == SLOT_LAST);
  // armed stage guarantees at least two edges from accept to execution
  assign exec_o    = armed_q && slot_free && mode_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      armed_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (!mode_en_i) begin
        pending_q <= 1'b0;
        armed_q   <= 1'b0;
      end else if (launch_i) begin
        pending_q <= 1'b1;
        armed_q   <= 1'b0;
      end else if (exec_o) begin
        pending_q <= 1'b0;
        armed_q   <= 1'b0;
      end else if (pending_q) begin
        armed_q   <= 1'b1;
      end
      if (launch_i)    done_q <= 1'b0;
      else if (exec_o) done_q <= 1'b1;
    end
  end

  assign busy_o = pending_q;
  assign done_o = done_q;
endmodule

// File: rtl/imc_mem_bank.sv
module imc_mem_bank
  import imc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CHANS   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  xfer_t             xfer_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_word_o
);
  localparam int DEPTH = NUM_STREAMS * NUM_CHANS;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic              cm_we;
  logic [DATA_W-1:0] cm_word [DEPTH];
  logic [DATA_W-1:0] dm_word;

  assign in_range = (int'(xfer_i.stream) < NUM_STREAMS) &&
                    (int'(xfer_i.chan) < NUM_CHANS);
  assign idx   = IDX_W'(int'(xfer_i.stream) * NUM_CHANS + int'(xfer_i.chan));
  assign cm_we = exec_i && xfer_i.is_wr && !xfer_i.data_mem && in_range;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          word_q <= '0;
      else if (cm_we && idx == IDX_W'(g))   word_q <= wdata_i;
    end
    assign cm_word[g] = word_q;
  end

  // read-only data memory image: ones above, channel and stream below
  always_comb begin
    dm_word = '1;
    dm_word[STREAM_W-1:0]                  = xfer_i.stream;
    dm_word[STREAM_W +: CHAN_W]            = xfer_i.chan;
  end

  always_comb begin
    if (!in_range)            rd_word_o = '0;
    else if (xfer_i.data_mem) rd_word_o = dm_word;
    else                      rd_word_o = cm_word[idx];
  end
endmodule

// File: rtl/ind_mem_ctrl.sv
module ind_mem_ctrl
  import imc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CHANS   = 32,
  parameter int SLOT_PERIOD = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              launch, exec, busy, done;
  logic              mode_en, wr_start, rd_start;
  logic              rd_load;
  xfer_t             xfer;
  logic [DATA_W-1:0] wdata_reg;
  logic [DATA_W-1:0] rd_word;

  assign rd_load = exec && !xfer.is_wr;

  imc_host_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .busy_i      (busy),
    .exec_i      (exec),
    .done_i      (done),
    .rd_load_i   (rd_load),
    .rd_word_i   (rd_word),
    .launch_o    (launch),
    .xfer_o      (xfer),
    .wdata_reg_o (wdata_reg),
    .mode_en_o   (mode_en),
    .wr_start_o  (wr_start),
    .rd_start_o  (rd_start)
  );

  imc_access_seq #(.SLOT_PERIOD(SLOT_PERIOD)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .mode_en_i (mode_en),
    .busy_o    (busy),
    .exec_o    (exec),
    .done_o    (done)
  );

  imc_mem_bank #(
    .DATA_W      (DATA_W),
    .NUM_STREAMS (NUM_STREAMS),
    .NUM_CHANS   (NUM_CHANS)
  ) i_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exec_i    (exec),
    .xfer_i    (xfer),
    .wdata_i   (wdata_reg),
    .rd_word_o (rd_word)
  );
endmodule

// File: rtl/ind_mem_ctrl_chk.sv
module ind_mem_ctrl_chk #(
  parameter int SLOT_PERIOD = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic launch_i,
  input logic exec_i,
  input logic busy_i,
  input logic done_i,
  input logic mode_en_i,
  input logic wr_start_i,
  input logic rd_start_i
);
  logic [7:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      lat_q <= '0;
    else if (launch_i)                lat_q <= 8'd1;
    else if (busy_i && lat_q != '1)   lat_q <= lat_q + 8'd1;
  end

  a_r5_latency_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |-> (lat_q >= 8'd2 && int'(lat_q) <= SLOT_PERIOD + 1));

  a_r5_start_clears_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> (!wr_start_i && !rd_start_i && done_i));

  a_r6_done_clears_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> !done_i);

  a_r6_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !launch_i) |=> done_i);

  a_r7_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_start_i, rd_start_i}));

  a_r8_no_launch_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !launch_i);

  a_r2_mode_off_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> (!busy_i && !wr_start_i && !rd_start_i));
endmodule

bind ind_mem_ctrl ind_mem_ctrl_chk #(.SLOT_PERIOD(SLOT_PERIOD)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .launch_i   (launch),
  .exec_i     (exec),
  .busy_i     (busy),
  .done_i     (done),
  .mode_en_i  (mode_en),
  .wr_start_i (wr_start),
  .rd_start_i (rd_start)
);

// File: tb/test_ind_mem_ctrl.sv
module test_ind_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ind_mem_ctrl i_ind_mem_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  sel;
    logic [4:0]  st;
    logic [6:0]  ch;
    logic [15:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 5'd0, 7'd0,  16'h1234, 4'd3},
    '{1'b1, 3'd0, 5'd3, 7'd31, 16'hBEEF, 4'd3},
    '{1'b1, 3'd0, 5'd1, 7'd5,  16'h00FF, 4'd3},
    '{1'b0, 3'd0, 5'd0, 7'd0,  16'h1234, 4'd4},
    '{1'b0, 3'd0, 5'd3, 7'd31, 16'hBEEF, 4'd4},
    '{1'b0, 3'd0, 5'd1, 7'd5,  16'h00FF, 4'd4},
    '{1'b0, 3'd0, 5'd2, 7'd2,  16'h0000, 4'd4},
    '{1'b1, 3'd1, 5'd1, 7'd5,  16'hAAAA, 4'd9},
    '{1'b0, 3'd1, 5'd1, 7'd5,  16'hF0A1, 4'd9},
    '{1'b0, 3'd0, 5'd1, 7'd5,  16'h00FF, 4'd9},
    '{1'b0, 3'd1, 5'd3, 7'd31, 16'hF3E3, 4'd9},
    '{1'b0, 3'd0, 5'd1, 7'd40, 16'h0000, 4'd10},
    '{1'b1, 3'd0, 5'd5, 7'd1,  16'h7777, 4'd10},
    '{1'b0, 3'd0, 5'd5, 7'd1,  16'h0000, 4'd10},
    '{1'b0, 3'd0, 5'd1, 7'd1,  16'h0000, 4'd10},
    '{1'b1, 3'd4, 5'd2, 7'd7,  16'h5A5A, 4'd3},
    '{1'b0, 3'd2, 5'd2, 7'd7,  16'h5A5A, 4'd4}
  };

  function automatic string req_name(logic [3:0] r);
    case (r)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] abuf_word(bit w, bit r, logic [4:0] st, logic [6:0] ch);
    return {2'b00, w, r, ch, st};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_lat(string req, int lat);
    n_tests++;
    if (lat < 2 || lat > 5) begin
      n_fail++;
      $display("FAIL %s actual latency=%0d expected=2..5", req, lat);
    end
  endtask

  // callers start at a falling edge
  task automatic host_wr(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic host_rd(logic [1:0] a, output logic [15:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
    @(negedge clk);
  endtask

  task automatic wait_done(output int lat);
    lat = 99;
    addr = 2'd2;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (rdata[14]) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic xfer(bit w, bit r, logic [2:0] sel, logic [4:0] st, logic [6:0] ch,
                      logic [15:0] wd, output int lat);
    host_wr(2'd0, {12'd0, sel, 1'b1});
    host_wr(2'd1, wd);
    host_wr(2'd2, abuf_word(w, r, st, ch));
    wait_done(lat);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v, prev;
    int lat;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      host_rd(2'(a), v);
      check("R1", v, 16'h0000);
    end

    // R2 mode disabled: start ignored
    host_wr(2'd2, abuf_word(1'b0, 1'b1, 5'd1, 7'd1));
    repeat (8) @(negedge clk);
    host_rd(2'd2, v);
    check("R2 start ignored", v, 16'h0021);
    host_rd(2'd3, v);
    check("R2 no read", v, 16'h0000);

    // R11 zero-wait read of control, data-read not writable
    host_wr(2'd0, 16'h000B);
    host_rd(2'd0, v);
    check("R11 ctrl readback", v, 16'h000B);
    host_wr(2'd3, 16'hFFFF);
    host_rd(2'd3, v);
    check("R11 data-read write ignored", v, 16'h0000);

    // vector table
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, !VECS[i].wr, VECS[i].sel, VECS[i].st, VECS[i].ch,
           VECS[i].wr ? VECS[i].val : 16'h0000, lat);
      check_lat("R5", lat);
      host_rd(2'd2, v);
      check("R5 start cleared", {14'd0, v[13:12]}, 16'h0000);
      if (!VECS[i].wr) begin
        host_rd(2'd3, v);
        check(req_name(VECS[i].req), v, VECS[i].val);
      end
    end

    // R7 both start bits rise together
    host_wr(2'd1, 16'h4321);
    host_wr(2'd2, abuf_word(1'b1, 1'b1, 5'd1, 7'd5));
    host_rd(2'd2, v);
    check("R7 only write start", {14'd0, v[13:12]}, 16'h0002);
    wait_done(lat);
    check_lat("R7", lat);
    host_rd(2'd3, v);
    check("R7 data-read kept", v, 16'h5A5A);
    xfer(1'b0, 1'b1, 3'd0, 5'd1, 7'd5, 16'h0, lat);
    host_rd(2'd3, v);
    check("R3 R7 written", v, 16'h4321);

    // R6 done persists, then clears on next accept
    repeat (10) @(negedge clk);
    host_rd(2'd2, v);
    check("R6 done held", {15'd0, v[14]}, 16'h0001);
    host_wr(2'd2, abuf_word(1'b0, 1'b1, 5'd0, 7'd0));
    host_rd(2'd2, v);
    check("R6 done cleared", {15'd0, v[14]}, 16'h0000);
    wait_done(lat);

    // R8 hammer start writes across the whole pending window
    host_wr(2'd1, 16'h1111);
    host_wr(2'd2, abuf_word(1'b1, 1'b0, 5'd0, 7'd0));
    host_wr(2'd1, 16'h9999);
    addr = 2'd2; wdata = abuf_word(1'b0, 1'b1, 5'd3, 7'd31); we = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (rdata[14]) break;
    end
    we = 1'b0;
    host_rd(2'd2, v);
    check("R8 coinciding start ignored", v, 16'h4000);
    xfer(1'b0, 1'b1, 3'd0, 5'd0, 7'd0, 16'h0, lat);
    host_rd(2'd3, v);
    check("R8 memory holds first data", v, 16'h1111);

    // R2 cancel by clearing mode enable
    host_rd(2'd3, prev);
    host_wr(2'd2, abuf_word(1'b0, 1'b1, 5'd3, 7'd31));
    host_wr(2'd0, 16'h0000);
    repeat (8) @(negedge clk);
    host_rd(2'd2, v);
    check("R2 cancelled", v, 16'h03E3);
    host_rd(2'd3, v);
    check("R2 data-read unchanged", v, prev);

    finished = 1'b1;
    finish_run();
  end
endmodule